// File: doc/BRIEF.md
# Interrupt Controller Command and Initialization Decoder

This block is the byte-wide programming port of one eight-input interrupt controller unit. Software talks to it through a one-bit address, a write strobe, a read strobe and an 8-bit data bus. The block decodes the initialization word series and the operation commands. It turns them into single-cycle strobes and values for an external register file, which holds the request, in-service, mask and rotation-offset registers. It also holds the vector base and the mode flags. It returns a byte from the read-back multiplexer, including the result of a poll.

Priority resolution among pending requests and cascade acknowledge are outside this block. The external resolver supplies the poll winner on `poll_valid`/`poll_idx`. The block searches only the in-service register, starting at the rotation offset, to find the target of a non-specific end-of-interrupt.

The initialization sequencer has four named states:
- `ST_NORMAL`: mask writes are accepted.
- `ST_GET_BASE`: waits for the vector base.
- `ST_SKIP_WORD`: the next data word is consumed and discarded.
- `ST_GET_MODE`: waits for the optional mode word.

The transitions are:
- start (any state, command-port write with bit 4 set) goes to `ST_GET_BASE`.
- base_taken goes from `ST_GET_BASE` to `ST_SKIP_WORD`.
- skip_to_normal goes from `ST_SKIP_WORD` to `ST_NORMAL` when no mode word was announced.
- skip_to_mode goes from `ST_SKIP_WORD` to `ST_GET_MODE` when a mode word was announced.
- mode_taken goes from `ST_GET_MODE` to `ST_NORMAL`.
- mask_write keeps `ST_NORMAL`.

Top module: `irqc_cmd_decoder`

## Requirements
- R1: A write at address 0 with data bit 4 set pulses `init_pulse` in that cycle, which tells the register file to clear mask, rotation offset, previous-level state and edge-triggered requests. The same write enters `ST_GET_BASE`, clears `special_mask`, and resets read selection to the request register.
- R2: When that start word has bit 0 clear, `nested_mode` and `auto_eoi` are both 0 from the next cycle.
- R3: The first address-1 write after a start sets `vec_base` to the data AND 0xF8. The second is discarded without a `mask_load`. The sequencer then goes to `ST_NORMAL`, or to `ST_GET_MODE` if the start word had bit 0 set.
- R4: In `ST_GET_MODE`, data bit 4 loads `nested_mode` and bit 1 loads `auto_eoi`. In `ST_NORMAL`, an address-1 write pulses `mask_load` with `mask_value` equal to the data.
- R5: An address-0 write with bit 4 clear and bit 3 set is a mode command. Bit 2 arms poll. When bit 1 is set, bit 0 selects in-service (1) or request (0) for reads. When bit 6 is set, bit 5 loads `special_mask`.
- R6: An address-0 write with bits 4 and 3 clear takes command code bits 7:5. Codes 1 and 5 clear the first in-service bit found by searching upward from the rotation offset, modulo 8. Code 5 also loads the rotation offset with that index + 1, modulo 8.
- R7: Code 3 clears the in-service bit given by data bits 2:0. Code 6 loads the offset with bits 2:0 + 1. Code 7 does both for the index in bits 2:0. Codes 0 and 4 load `rot_on_aeoi` from bit 7. Code 2 has no effect.
- R8: A read strobe updates `rdata` at that clock edge. Address 0 returns the in-service or request register according to the selection, and address 1 returns the mask.
- R9: A read while poll is armed ignores the address. With a winner it returns 0x80 OR the index and pulses `req_clr` and `isr_clr` for that index in the read cycle. With no winner it returns 0x07. Poll is disarmed afterwards.
- R10: A non-specific end-of-interrupt (code 1 or 5) with an empty in-service register pulses neither `isr_clr` nor `rot_load`.
- R11: All strobes are combinational single-cycle pulses aligned with the write or read strobe. A read strobe that coincides with a write strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 1 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered at the read edge |
| req_in | input | 8 | Current request register |
| isr_in | input | 8 | Current in-service register |
| mask_in | input | 8 | Current mask register |
| rot_off | input | 3 | Current rotation offset |
| poll_valid | input | 1 | Resolver has a winning request |
| poll_idx | input | 3 | Resolver's winning index |
| init_pulse | output | 1 | Initialization clear strobe |
| mask_load | output | 1 | Mask register load strobe |
| mask_value | output | 8 | Value for the mask register |
| isr_clr | output | 1 | In-service bit clear strobe |
| isr_clr_idx | output | 3 | In-service bit to clear |
| req_clr | output | 1 | Request bit clear strobe (poll) |
| req_clr_idx | output | 3 | Request bit to clear |
| rot_load | output | 1 | Rotation offset load strobe |
| rot_value | output | 3 | New rotation offset |
| vec_base | output | 8 | Vector base, low three bits zero |
| nested_mode | output | 1 | Nested-mode flag |
| auto_eoi | output | 1 | Automatic end-of-interrupt flag |
| rot_on_aeoi | output | 1 | Rotate-on-automatic-EOI flag |
| special_mask | output | 1 | Special-mask flag |

## Verification
On every cycle, the assertions check the following relations:
- every strobe coincides with a write or read strobe;
- a combined clear-and-rotate names the successor of the cleared index;
- an empty in-service register never yields a non-specific clear;
- the vector base holds without writes;
- a consuming poll read returns the flagged index;
- a start word without a mode word leaves both nested and auto-EOI flags low.

The following can only be shown by the bench's scenarios:
- the ordering of the initialization words (the discarded second word, and mask writes resuming only after the sequence);
- the modulo-8 wrap of the in-service search and rotation values;
- read-selection persistence across commands;
- poll disarming after exactly one read.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int DW = 8;

    typedef enum logic [1:0] {
        ST_NORMAL    = 2'd0,
        ST_GET_BASE  = 2'd1,
        ST_SKIP_WORD = 2'd2,
        ST_GET_MODE  = 2'd3
    } init_state_e;

    localparam logic [2:0] CMD_ROT_AEOI_CLR = 3'd0;
    localparam logic [2:0] CMD_EOI_NS       = 3'd1;
    localparam logic [2:0] CMD_NOP          = 3'd2;
    localparam logic [2:0] CMD_EOI_SP       = 3'd3;
    localparam logic [2:0] CMD_ROT_AEOI_SET = 3'd4;
    localparam logic [2:0] CMD_EOI_NS_ROT   = 3'd5;
    localparam logic [2:0] CMD_SET_PRIO     = 3'd6;
    localparam logic [2:0] CMD_EOI_SP_ROT   = 3'd7;
endpackage

// File: rtl/irqc_init_fsm.sv
module irqc_init_fsm
    import irqc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          addr,
    input  logic [DW-1:0] wdata,
    output logic          init_pulse,
    output logic          mask_load,
    output logic [DW-1:0] vec_base,
    output logic          nested_mode,
    output logic          auto_eoi
);
    localparam logic [DW-1:0] BASE_MASK = 8'hF8;

    init_state_e state_q, state_d;
    logic        need_mode_q;
    logic        is_start;
    logic        data_wr;

    assign is_start = wr_en && !addr && wdata[4];
    assign data_wr  = wr_en && addr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_NORMAL;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (is_start) begin
            state_d = ST_GET_BASE;
        end else if (data_wr) begin
            unique case (state_q)
                ST_NORMAL:    state_d = ST_NORMAL;
                ST_GET_BASE:  state_d = ST_SKIP_WORD;
                ST_SKIP_WORD: state_d = need_mode_q ? ST_GET_MODE : ST_NORMAL;
                ST_GET_MODE:  state_d = ST_NORMAL;
            endcase
        end
    end

    // outputs
    always_comb begin
        init_pulse = is_start;
        mask_load  = data_wr && (state_q == ST_NORMAL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            need_mode_q <= 1'b0;
            vec_base    <= '0;
            nested_mode <= 1'b0;
            auto_eoi    <= 1'b0;
        end else if (is_start) begin
            need_mode_q <= wdata[0];
            if (!wdata[0]) begin
                nested_mode <= 1'b0;
                auto_eoi    <= 1'b0;
            end
        end else if (data_wr) begin
            if (state_q == ST_GET_BASE) vec_base <= wdata & BASE_MASK;
            if (state_q == ST_GET_MODE) begin
                nested_mode <= wdata[4];
                auto_eoi    <= wdata[1];
            end
        end
    end
endmodule

// File: rtl/irqc_ocw_decode.sv
module irqc_ocw_decode
    import irqc_pkg::*;
#(
    parameter int LINES = 8,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_go,
    input  logic             addr,
    input  logic [DW-1:0]    wdata,
    input  logic [LINES-1:0] isr_in,
    input  logic [IDX_W-1:0] rot_off,
    output logic             eoi_clr,
    output logic [IDX_W-1:0] eoi_idx,
    output logic             rot_load,
    output logic [IDX_W-1:0] rot_value,
    output logic             poll_armed,
    output logic             read_isr,
    output logic             rot_on_aeoi,
    output logic             special_mask
);
    logic             cmd_wr, mode_wr, start_wr;
    logic [2:0]       code;
    logic             hi_found;
    logic [IDX_W-1:0] hi_idx, cand;
    logic [IDX_W-1:0] given;

    assign start_wr = wr_en && !addr && wdata[4];
    assign mode_wr  = wr_en && !addr && !wdata[4] && wdata[3];
    assign cmd_wr   = wr_en && !addr && !wdata[4] && !wdata[3];
    assign code     = wdata[7:5];
    assign given    = wdata[IDX_W-1:0];

    // first in-service bit upward from the rotation offset, wrapping
    always_comb begin
        hi_found = 1'b0;
        hi_idx   = '0;
        cand     = '0;
        for (int k = 0; k < LINES; k++) begin
            cand = rot_off + IDX_W'(k);
            if (!hi_found && isr_in[cand]) begin
                hi_found = 1'b1;
                hi_idx   = cand;
            end
        end
    end

    always_comb begin
        eoi_clr   = 1'b0;
        eoi_idx   = '0;
        rot_load  = 1'b0;
        rot_value = '0;
        if (cmd_wr) begin
            unique case (code)
                CMD_EOI_NS, CMD_EOI_NS_ROT: begin
                    eoi_clr   = hi_found;
                    eoi_idx   = hi_idx;
                    rot_load  = hi_found && (code == CMD_EOI_NS_ROT);
                    rot_value = hi_idx + 1'b1;
                end
                CMD_EOI_SP: begin
                    eoi_clr = 1'b1;
                    eoi_idx = given;
                end
                CMD_SET_PRIO: begin
                    rot_load  = 1'b1;
                    rot_value = given + 1'b1;
                end
                CMD_EOI_SP_ROT: begin
                    eoi_clr   = 1'b1;
                    eoi_idx   = given;
                    rot_load  = 1'b1;
                    rot_value = given + 1'b1;
                end
                CMD_ROT_AEOI_CLR, CMD_ROT_AEOI_SET, CMD_NOP: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            poll_armed   <= 1'b0;
            read_isr     <= 1'b0;
            rot_on_aeoi  <= 1'b0;
            special_mask <= 1'b0;
        end else begin
            if (start_wr) begin
                read_isr     <= 1'b0;
                special_mask <= 1'b0;
            end
            if (mode_wr) begin
                if (wdata[2]) poll_armed   <= 1'b1;
                if (wdata[1]) read_isr     <= wdata[0];
                if (wdata[6]) special_mask <= wdata[5];
            end else if (rd_go) begin
                poll_armed <= 1'b0;
            end
            if (cmd_wr && (code == CMD_ROT_AEOI_CLR || code == CMD_ROT_AEOI_SET))
                rot_on_aeoi <= wdata[7];
        end
    end
endmodule

// File: rtl/irqc_readback.sv
module irqc_readback
    import irqc_pkg::*;
#(
    parameter int LINES = 8,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_go,
    input  logic             addr,
    input  logic             poll_armed,
    input  logic             read_isr,
    input  logic [LINES-1:0] req_in,
    input  logic [LINES-1:0] isr_in,
    input  logic [LINES-1:0] mask_in,
    input  logic             poll_valid,
    input  logic [IDX_W-1:0] poll_idx,
    output logic             poll_clr,
    output logic [DW-1:0]    rdata
);
    localparam logic [DW-1:0] POLL_NONE = DW'({IDX_W{1'b1}});

    logic [DW-1:0] sel;

    assign poll_clr = rd_go && poll_armed && poll_valid;

    always_comb begin
        if (poll_armed)
            sel = poll_valid ? ({1'b1, {(DW-1){1'b0}}} | DW'(poll_idx)) : POLL_NONE;
        else if (addr)
            sel = DW'(mask_in);
        else
            sel = read_isr ? DW'(isr_in) : DW'(req_in);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_go) rdata <= sel;
    end
endmodule

// File: rtl/irqc_cmd_decoder.sv
module irqc_cmd_decoder
    import irqc_pkg::*;
#(
    parameter int LINES = 8,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    input  logic [LINES-1:0] req_in,
    input  logic [LINES-1:0] isr_in,
    input  logic [LINES-1:0] mask_in,
    input  logic [IDX_W-1:0] rot_off,
    input  logic             poll_valid,
    input  logic [IDX_W-1:0] poll_idx,
    output logic             init_pulse,
    output logic             mask_load,
    output logic [DW-1:0]    mask_value,
    output logic             isr_clr,
    output logic [IDX_W-1:0] isr_clr_idx,
    output logic             req_clr,
    output logic [IDX_W-1:0] req_clr_idx,
    output logic             rot_load,
    output logic [IDX_W-1:0] rot_value,
    output logic [DW-1:0]    vec_base,
    output logic             nested_mode,
    output logic             auto_eoi,
    output logic             rot_on_aeoi,
    output logic             special_mask
);
    logic             rd_go;
    logic             eoi_clr, poll_clr, poll_armed, read_isr;
    logic [IDX_W-1:0] eoi_idx;

    assign rd_go = rd_en && !wr_en;

    irqc_init_fsm u_init (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .init_pulse(init_pulse), .mask_load(mask_load), .vec_base(vec_base),
        .nested_mode(nested_mode), .auto_eoi(auto_eoi)
    );

    irqc_ocw_decode #(.LINES(LINES)) u_ocw (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_go(rd_go), .addr(addr),
        .wdata(wdata), .isr_in(isr_in), .rot_off(rot_off),
        .eoi_clr(eoi_clr), .eoi_idx(eoi_idx), .rot_load(rot_load),
        .rot_value(rot_value), .poll_armed(poll_armed), .read_isr(read_isr),
        .rot_on_aeoi(rot_on_aeoi), .special_mask(special_mask)
    );

    irqc_readback #(.LINES(LINES)) u_rb (
        .clk(clk), .rst_n(rst_n), .rd_go(rd_go), .addr(addr),
        .poll_armed(poll_armed), .read_isr(read_isr), .req_in(req_in),
        .isr_in(isr_in), .mask_in(mask_in), .poll_valid(poll_valid),
        .poll_idx(poll_idx), .poll_clr(poll_clr), .rdata(rdata)
    );

    assign mask_value  = wdata;
    assign isr_clr     = eoi_clr || poll_clr;
    assign isr_clr_idx = eoi_clr ? eoi_idx : poll_idx;
    assign req_clr     = poll_clr;
    assign req_clr_idx = poll_idx;
endmodule

// File: rtl/irqc_cmd_decoder_checker.sv
module irqc_cmd_decoder_checker #(
    parameter int LINES = 8,
    localparam int IDX_W = $clog2(LINES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             addr,
    input logic             wr_en,
    input logic             rd_en,
    input logic [7:0]       wdata,
    input logic [7:0]       rdata,
    input logic [LINES-1:0] isr_in,
    input logic             init_pulse,
    input logic             mask_load,
    input logic             isr_clr,
    input logic [IDX_W-1:0] isr_clr_idx,
    input logic             req_clr,
    input logic [IDX_W-1:0] req_clr_idx,
    input logic             rot_load,
    input logic [IDX_W-1:0] rot_value,
    input logic [7:0]       vec_base,
    input logic             nested_mode,
    input logic             auto_eoi
);
    p_no_mode_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata[4] && !wdata[0]) |=> (!nested_mode && !auto_eoi));

    p_base_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(vec_base));

    p_rot_successor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_clr && rot_load && wr_en) |-> (rot_value == isr_clr_idx + 1'b1));

    p_poll_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && req_clr) |=> (rdata[7] && rdata[IDX_W-1:0] == $past(req_clr_idx)));

    p_empty_eoi_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata[4:3] == 2'b00 && wdata[6:5] == 2'b01 && isr_in == '0)
        |-> (!isr_clr && !rot_load));

    p_strobe_align_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (init_pulse || mask_load || isr_clr || req_clr || rot_load) |-> (wr_en || rd_en));
endmodule

bind irqc_cmd_decoder irqc_cmd_decoder_checker #(.LINES(LINES)) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .isr_in(isr_in), .init_pulse(init_pulse),
    .mask_load(mask_load), .isr_clr(isr_clr), .isr_clr_idx(isr_clr_idx),
    .req_clr(req_clr), .req_clr_idx(req_clr_idx), .rot_load(rot_load),
    .rot_value(rot_value), .vec_base(vec_base), .nested_mode(nested_mode),
    .auto_eoi(auto_eoi)
);

// File: tb/irqc_cmd_decoder_test.sv
`timescale 1ns/1ps
module irqc_cmd_decoder_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0, rdata;
    logic [7:0] req_in = 8'h81, isr_in = '0, mask_in = 8'h5A;
    logic [2:0] rot_off = '0, poll_idx = '0;
    logic       poll_valid = 1'b0;
    logic       init_pulse, mask_load, isr_clr, req_clr, rot_load;
    logic [7:0] mask_value, vec_base;
    logic [2:0] isr_clr_idx, req_clr_idx, rot_value;
    logic       nested_mode, auto_eoi, rot_on_aeoi, special_mask;

    int checks = 0, fails = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    irqc_cmd_decoder uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .req_in(req_in), .isr_in(isr_in),
        .mask_in(mask_in), .rot_off(rot_off), .poll_valid(poll_valid),
        .poll_idx(poll_idx), .init_pulse(init_pulse), .mask_load(mask_load),
        .mask_value(mask_value), .isr_clr(isr_clr), .isr_clr_idx(isr_clr_idx),
        .req_clr(req_clr), .req_clr_idx(req_clr_idx), .rot_load(rot_load),
        .rot_value(rot_value), .vec_base(vec_base), .nested_mode(nested_mode),
        .auto_eoi(auto_eoi), .rot_on_aeoi(rot_on_aeoi), .special_mask(special_mask)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_begin(logic a, logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        #0.5;
    endtask

    task automatic rd_begin(logic a, logic [7:0] exp, string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        #0.5;
    endtask

    task automatic op_end();
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        #0.5;
    endtask

    task automatic wr(logic a, logic [7:0] d);
        wr_begin(a, d);
        op_end();
    endtask

    task automatic rd(logic a, logic [7:0] exp, string tag);
        rd_begin(a, exp, tag);
        op_end();
    endtask

    // monitor: pops expected read data and compares after the read edge
    initial forever begin
        @(posedge clk);
        if (rd_en && !wr_en) begin
            #1;
            chk(tag_q.pop_front(), rdata, exp_q.pop_front());
        end
    end

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        chk("reset vec_base", vec_base, 0);
        chk("reset flags", {nested_mode, auto_eoi, rot_on_aeoi, special_mask}, 0);
        chk("reset rdata", rdata, 0);

        // R1/R3/R4: start with mode word
        wr_begin(1'b0, 8'h11);
        chk("R1 init_pulse", init_pulse, 1);
        op_end();
        chk("R11 init_pulse single", init_pulse, 0);
        wr_begin(1'b1, 8'h47);
        chk("R3 base word no mask_load", mask_load, 0);
        op_end();
        chk("R3 vec_base", vec_base, 8'h40);
        wr_begin(1'b1, 8'hAA);
        chk("R3 second word ignored", mask_load, 0);
        op_end();
        chk("R3 base kept", vec_base, 8'h40);
        wr_begin(1'b1, 8'h12);
        chk("R4 mode word no mask_load", mask_load, 0);
        op_end();
        chk("R4 nested/aeoi", {nested_mode, auto_eoi}, 2'b11);
        wr_begin(1'b1, 8'h5A);
        chk("R4 mask_load", {mask_load, mask_value}, {1'b1, 8'h5A});
        op_end();

        // R2/R3: start without mode word
        wr(1'b0, 8'h10);
        chk("R2 flags cleared", {nested_mode, auto_eoi}, 0);
        wr(1'b1, 8'h08);
        chk("R3 vec_base 2", vec_base, 8'h08);
        wr_begin(1'b1, 8'h00);
        chk("R3 skip word", mask_load, 0);
        op_end();
        wr_begin(1'b1, 8'h33);
        chk("R3 back to normal", {mask_load, mask_value}, {1'b1, 8'h33});
        op_end();
        chk("R2 flags stay", {nested_mode, auto_eoi}, 0);

        // R5/R8: mode command and read selection
        isr_in = 8'h24;
        wr(1'b0, 8'h6B);
        chk("R5 special_mask set", special_mask, 1);
        rd(1'b0, 8'h24, "R8 read in-service");
        rd(1'b1, 8'h5A, "R8 read mask");
        wr(1'b0, 8'h0A);
        rd(1'b0, 8'h81, "R5 read request");
        wr(1'b0, 8'h48);
        chk("R5 special_mask cleared", special_mask, 0);
        wr(1'b0, 8'h08);
        rd(1'b0, 8'h81, "R5 selection kept");

        // R6: non-specific EOI with wrap
        rot_off = 3'd0;
        wr_begin(1'b0, 8'h20);
        chk("R6 ns eoi", {isr_clr, isr_clr_idx, rot_load}, {1'b1, 3'd2, 1'b0});
        op_end();
        rot_off = 3'd3;
        wr_begin(1'b0, 8'hA0);
        chk("R6 ns eoi rot", {isr_clr, isr_clr_idx, rot_load, rot_value}, {1'b1, 3'd5, 1'b1, 3'd6});
        op_end();
        rot_off = 3'd6;
        wr_begin(1'b0, 8'hA0);
        chk("R6 ns eoi wrap", {isr_clr, isr_clr_idx, rot_load, rot_value}, {1'b1, 3'd2, 1'b1, 3'd3});
        op_end();
        chk("R11 strobes drop", {isr_clr, rot_load}, 0);

        // R10: empty in-service register
        isr_in = 8'h00;
        wr_begin(1'b0, 8'h20);
        chk("R10 empty ns eoi", {isr_clr, rot_load}, 0);
        op_end();
        wr_begin(1'b0, 8'hA0);
        chk("R10 empty ns eoi rot", {isr_clr, rot_load}, 0);
        op_end();

        // R7: specific commands
        wr_begin(1'b0, 8'h65);
        chk("R7 specific eoi", {isr_clr, isr_clr_idx, rot_load}, {1'b1, 3'd5, 1'b0});
        op_end();
        wr_begin(1'b0, 8'hC7);
        chk("R7 set priority", {isr_clr, rot_load, rot_value}, {1'b0, 1'b1, 3'd0});
        op_end();
        wr_begin(1'b0, 8'hE2);
        chk("R7 specific eoi rot", {isr_clr, isr_clr_idx, rot_load, rot_value}, {1'b1, 3'd2, 1'b1, 3'd3});
        op_end();
        wr_begin(1'b0, 8'h40);
        chk("R7 code 2 no effect", {isr_clr, rot_load}, 0);
        op_end();
        wr(1'b0, 8'h80);
        chk("R7 rot_on_aeoi set", rot_on_aeoi, 1);
        wr(1'b0, 8'h00);
        chk("R7 rot_on_aeoi clear", rot_on_aeoi, 0);

        // R9: poll reads
        wr(1'b0, 8'h0C);
        poll_valid = 1'b1; poll_idx = 3'd6;
        rd_begin(1'b1, 8'h86, "R9 poll winner");
        chk("R9 poll clears", {req_clr, req_clr_idx, isr_clr, isr_clr_idx}, {1'b1, 3'd6, 1'b1, 3'd6});
        op_end();
        rd_begin(1'b0, 8'h81, "R9 poll disarmed");
        chk("R9 no clear when disarmed", {req_clr, isr_clr}, 0);
        op_end();
        poll_valid = 1'b0;
        wr(1'b0, 8'h0C);
        rd_begin(1'b0, 8'h07, "R9 poll empty");
        chk("R9 empty no clear", req_clr, 0);
        op_end();

        // R11: read coinciding with write is ignored
        wr(1'b0, 8'h0C);
        poll_valid = 1'b1; poll_idx = 3'd1;
        @(negedge clk);
        addr = 1'b0; wdata = 8'h40; wr_en = 1'b1; rd_en = 1'b1;
        #0.5;
        chk("R11 overlapped read no clear", req_clr, 0);
        op_end();
        rd(1'b0, 8'h81, "R11 poll still armed");
        chk("R11 rdata from poll", rdata, 8'h81);

        // R1: start clears special mask and read selection
        wr(1'b0, 8'h6B);
        wr(1'b0, 8'h10);
        chk("R1 special_mask cleared", special_mask, 0);
        isr_in = 8'h24;
        rd(1'b0, 8'h81, "R1 selection reset");

        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule